// File: doc/BRIEF.md
# Multi-Cycle 16-bit Stack Machine Core

This block is a small multi-cycle processor. It runs a 22-opcode instruction set held in a 16-bit, word-addressed memory. An instruction is one opcode word followed by zero to three operand words. The core reads each word through a synchronous memory port, where read data returns one cycle after the request. It then decodes the operands and executes the instruction. The core holds eight general registers and a program counter. A return/data stack of `STACK_DEPTH` words lives in a private store, so stack traffic never touches program memory.

Every operand word is decoded the same way: it is either a literal or a register reference, and any other encoding stops the core. A separate combinational unit does the arithmetic and comparisons. Character output and input each use a valid/ready byte handshake. Two status outputs report the stop condition: `halted` for any stop, and `illegal` as well when the stop was caused by an error.

Top module: `vm16_core`

## Requirements
- R1: Opcode words 0..21 are, in order: halt, set, push, pop, eq, gt, jmp, jt, jf, add, mult, mod, and, or, not, rmem, wmem, call, ret, out, in, noop. An opcode word above 21 stops the core with `halted`=1 and `illegal`=1.
- R2: An operand word below 0x8000 is a literal. A word from 0x8000 to 0x8007 reads register R0..R7. A source operand of 0x8008 or above stops the core as illegal, and the instruction has no effect.
- R3: A destination operand (the first operand of set, pop, eq, gt, add, mult, mod, and, or, not, rmem, in) must lie in 0x8000..0x8007. Any other value stops the core as illegal.
- R4: After a sequential instruction the PC advances by its length in words:
  - 1 for halt, ret, noop
  - 2 for push, pop, jmp, call, out, in
  - 3 for set, jt, jf, not, rmem, wmem
  - 4 for eq, gt, add, mult, mod, and, or
- R5: jt jumps to its second operand when the first operand is nonzero. jf jumps when the first operand is zero. A branch that is not taken advances the PC by 3. jmp jumps to its operand.
- R6: The results written to the destination are as follows:
  - set: copies the operand
  - eq / gt: 1 or 0, comparing 16-bit values
  - add / mult: result modulo 32768
  - mod: remainder, or 0 when the divisor is 0
  - and / or: bitwise result
  - not: 15-bit bitwise inverse
- R7: push and pop work last-in first-out. A push or call when `STACK_DEPTH` entries are already held stops the core as illegal.
- R8: call pushes the address of the following instruction (PC+2) and jumps to its operand. ret pops a word and jumps to it.
- R9: pop or ret on an empty stack stops the core with `illegal`=1.
- R10: rmem loads the word at the address given by its second operand. wmem writes its second operand to the address given by its first operand, with one `mem_wr` pulse. A read request in one cycle has its data taken from `mem_rdata` in the next cycle.
- R11: out drives the low 8 bits of its operand on `out_data` with `out_valid`=1. Both are held stable until `out_ready` is seen, and execution then continues.
- R12: in raises `in_ready` and waits for `in_valid`, then stores `in_data` into the destination. The code 0x51 stops the core normally instead, with `halted`=1 and `illegal`=0.
- R13: Reset clears all registers, the PC and the stack, and the first fetch is from address 0. The halt opcode stops the core with `halted`=1 and `illegal`=0. A stopped core holds its state and makes no memory access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | output | 16 | Word address for fetch, rmem or wmem |
| mem_rd | output | 1 | Read request; data expected on the next cycle |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, one cycle after `mem_rd` |
| out_data | output | 8 | Output character |
| out_valid | output | 1 | Output character valid |
| out_ready | input | 1 | Output sink accepts the character |
| in_data | input | 8 | Input character |
| in_valid | input | 1 | Input character valid |
| in_ready | output | 1 | Core waits for an input character |
| halted | output | 1 | Core has stopped |
| illegal | output | 1 | Stop was caused by an error |

## Verification
Each instruction word costs two cycles: one to request it and one to capture it. Execution then takes one more cycle, so a wmem writes to memory at the end of cycle 2N+1 of an N-word instruction. rmem adds two cycles for its data read, and out and in stay in their wait state until the handshake completes. Because whole programs take data-dependent cycle counts, the bench waits for `halted` and then inspects its memory model and the status outputs. The handshake outputs are sampled on the falling edge while the core is known to be waiting, so a check never depends on the exact cycle an instruction retires.

// File: rtl/vm16_pkg.sv
package vm16_pkg;

  typedef enum logic [4:0] {
    OP_HALT = 5'd0, OP_SET, OP_PUSH, OP_POP, OP_EQ, OP_GT, OP_JMP, OP_JT,
    OP_JF, OP_ADD, OP_MULT, OP_MOD, OP_AND, OP_OR, OP_NOT, OP_RMEM,
    OP_WMEM, OP_CALL, OP_RET, OP_OUT, OP_IN, OP_NOOP
  } opcode_e;

  localparam logic [15:0] OP_LAST = 16'd21;

  typedef enum logic [2:0] {
    ST_FETCH, ST_LATCH, ST_EXEC, ST_MRD, ST_MCAP, ST_OUT, ST_IN, ST_STOP
  } state_e;

  // instruction length in words, opcode included
  function automatic logic [2:0] insn_len(input logic [4:0] op);
    case (op)
      5'd0, 5'd18, 5'd21:                       return 3'd1;
      5'd2, 5'd3, 5'd6, 5'd17, 5'd19, 5'd20:    return 3'd2;
      5'd1, 5'd7, 5'd8, 5'd14, 5'd15, 5'd16:    return 3'd3;
      default:                                  return 3'd4;
    endcase
  endfunction

  // operand slots [3:1] read as sources
  function automatic logic [3:1] src_slots(input opcode_e op);
    case (op)
      OP_SET, OP_NOT, OP_RMEM:                          return 3'b010;
      OP_PUSH, OP_JMP, OP_CALL, OP_OUT:                 return 3'b001;
      OP_JT, OP_JF, OP_WMEM:                            return 3'b011;
      OP_EQ, OP_GT, OP_ADD, OP_MULT, OP_MOD,
      OP_AND, OP_OR:                                    return 3'b110;
      default:                                          return 3'b000;
    endcase
  endfunction

  // slot 1 names a destination register
  function automatic logic has_dst(input opcode_e op);
    case (op)
      OP_SET, OP_POP, OP_EQ, OP_GT, OP_ADD, OP_MULT, OP_MOD,
      OP_AND, OP_OR, OP_NOT, OP_RMEM, OP_IN: return 1'b1;
      default:                               return 1'b0;
    endcase
  endfunction

  function automatic logic [15:0] f_add15(input logic [15:0] b, input logic [15:0] c);
    return (b + c) & 16'h7fff;
  endfunction

  function automatic logic [15:0] f_mul15(input logic [15:0] b, input logic [15:0] c);
    return (b * c) & 16'h7fff;
  endfunction

  function automatic logic [15:0] f_mod(input logic [15:0] b, input logic [15:0] c);
    return (c == 16'd0) ? 16'd0 : (b % c);
  endfunction

  function automatic logic [15:0] f_inv15(input logic [15:0] b);
    return ~b & 16'h7fff;
  endfunction

endpackage

// File: rtl/vm16_alu.sv
module vm16_alu
  import vm16_pkg::*;
(
  input  opcode_e     op,
  input  logic [15:0] b,
  input  logic [15:0] c,
  output logic [15:0] res
);

  always_comb begin
    case (op)
      OP_EQ:   res = {15'd0, b == c};
      OP_GT:   res = {15'd0, b > c};
      OP_ADD:  res = f_add15(b, c);
      OP_MULT: res = f_mul15(b, c);
      OP_MOD:  res = f_mod(b, c);
      OP_AND:  res = b & c;
      OP_OR:   res = b | c;
      OP_NOT:  res = f_inv15(b);
      default: res = b;
    endcase
  end

endmodule

// File: rtl/vm16_stack.sv
module vm16_stack #(
  parameter int DEPTH = 64,
  parameter int W     = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] top,
  output logic         empty,
  output logic         full
);

  localparam int CW = $clog2(DEPTH + 1);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  store [DEPTH];
  logic [CW-1:0] cnt;
  logic [CW-1:0] cnt_m1;

  assign cnt_m1 = cnt - CW'(1);
  assign top    = store[AW'(cnt_m1)];
  assign empty  = (cnt == '0);
  assign full   = (cnt == CW'(DEPTH));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (push) cnt <= cnt + CW'(1);
    else if (pop)  cnt <= cnt_m1;
  end

  always_ff @(posedge clk) begin
    if (push) store[AW'(cnt)] <= wdata;
  end

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  p_no_underflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);

endmodule

// File: rtl/vm16_core.sv
module vm16_core
  import vm16_pkg::*;
#(
  parameter int STACK_DEPTH = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  output logic [15:0] mem_addr,
  output logic        mem_rd,
  output logic        mem_wr,
  output logic [15:0] mem_wdata,
  input  logic [15:0] mem_rdata,
  output logic [7:0]  out_data,
  output logic        out_valid,
  input  logic        out_ready,
  input  logic [7:0]  in_data,
  input  logic        in_valid,
  output logic        in_ready,
  output logic        halted,
  output logic        illegal
);

  localparam int          NREG    = 8;
  localparam logic [7:0]  QUIT_CH = 8'h51;

  state_e       st;
  opcode_e      op;
  logic [15:0]  pc;
  logic [1:0]   idx;
  logic [15:0]  opw  [1:3];
  logic [15:0]  regs [NREG];

  // decoded operands
  logic [15:0]  opv  [1:3];
  logic [3:1]   bad;
  logic         dst_bad, opnd_err, stack_err, exec_err;
  logic [2:0]   step_len;

  for (genvar k = 1; k <= 3; k++) begin : g_opnd
    assign opv[k] = opw[k][15] ? regs[opw[k][2:0]] : opw[k];
    assign bad[k] = opw[k][15] && (opw[k][14:3] != 12'd0);
  end

  assign dst_bad   = (opw[1][15:3] != 13'h1000);
  assign step_len  = insn_len(op);

  // stack
  logic        stk_push, stk_pop, stk_empty, stk_full;
  logic [15:0] stk_wdata, stk_top;
  logic        is_push_op, is_pop_op;

  assign is_push_op = (op == OP_PUSH) || (op == OP_CALL);
  assign is_pop_op  = (op == OP_POP)  || (op == OP_RET);
  assign opnd_err   = |(src_slots(op) & bad) || (has_dst(op) && dst_bad);
  assign stack_err  = (is_push_op && stk_full) || (is_pop_op && stk_empty);
  assign exec_err   = opnd_err || stack_err;

  // named events
  logic ev_exec_ok, ev_seq_retire, ev_in_take, ev_quit;
  assign ev_exec_ok    = (st == ST_EXEC) && !exec_err;
  assign ev_seq_retire = ev_exec_ok && !(op inside {OP_HALT, OP_JMP, OP_JT, OP_JF,
                          OP_CALL, OP_RET, OP_RMEM, OP_OUT, OP_IN});
  assign ev_in_take    = (st == ST_IN) && in_valid;
  assign ev_quit       = ev_in_take && (in_data == QUIT_CH);

  assign stk_push  = ev_exec_ok && is_push_op;
  assign stk_pop   = ev_exec_ok && is_pop_op;
  assign stk_wdata = (op == OP_PUSH) ? opv[1] : pc + 16'd2;

  vm16_stack #(.DEPTH(STACK_DEPTH), .W(16)) u_stack (
    .clk(clk), .rst_n(rst_n), .push(stk_push), .pop(stk_pop),
    .wdata(stk_wdata), .top(stk_top), .empty(stk_empty), .full(stk_full)
  );

  // arithmetic
  logic [15:0] alu_res;
  vm16_alu u_alu (.op(op), .b(opv[2]), .c(opv[3]), .res(alu_res));

  // register write port
  logic        rf_we;
  logic [15:0] rf_wd;
  assign rf_we = (ev_exec_ok && has_dst(op) && op != OP_RMEM && op != OP_IN)
               || (st == ST_MCAP) || (ev_in_take && !ev_quit);
  always_comb begin
    if (st == ST_MCAP)      rf_wd = mem_rdata;
    else if (st == ST_IN)   rf_wd = {8'd0, in_data};
    else if (op == OP_POP)  rf_wd = stk_top;
    else                    rf_wd = alu_res;
  end

  // memory and I/O ports
  assign mem_rd    = (st == ST_FETCH) || (st == ST_MRD);
  assign mem_wr    = ev_exec_ok && (op == OP_WMEM);
  assign mem_wdata = opv[2];
  always_comb begin
    case (st)
      ST_FETCH: mem_addr = pc + {14'd0, idx};
      ST_MRD:   mem_addr = opv[2];
      default:  mem_addr = opv[1];
    endcase
  end
  assign out_valid = (st == ST_OUT);
  assign out_data  = opv[1][7:0];
  assign in_ready  = (st == ST_IN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_FETCH;
      op      <= OP_NOOP;
      pc      <= '0;
      idx     <= '0;
      halted  <= 1'b0;
      illegal <= 1'b0;
      for (int k = 1; k <= 3; k++) opw[k] <= '0;
      for (int r = 0; r < NREG; r++) regs[r] <= '0;
    end else begin
      case (st)
        ST_FETCH: st <= ST_LATCH;
        ST_LATCH: begin
          if (idx == 2'd0) begin
            if (mem_rdata > OP_LAST) begin
              st <= ST_STOP; halted <= 1'b1; illegal <= 1'b1;
            end else begin
              op <= opcode_e'(mem_rdata[4:0]);
              if (insn_len(mem_rdata[4:0]) == 3'd1) st <= ST_EXEC;
              else begin idx <= 2'd1; st <= ST_FETCH; end
            end
          end else begin
            opw[idx] <= mem_rdata;
            if ({1'b0, idx} + 3'd1 == step_len) st <= ST_EXEC;
            else begin idx <= idx + 2'd1; st <= ST_FETCH; end
          end
        end
        ST_EXEC: begin
          idx <= '0;
          if (exec_err) begin
            st <= ST_STOP; halted <= 1'b1; illegal <= 1'b1;
          end else begin
            st <= ST_FETCH;
            case (op)
              OP_HALT: begin st <= ST_STOP; halted <= 1'b1; end
              OP_JMP, OP_CALL: pc <= opv[1];
              OP_JT:   pc <= (opv[1] != 16'd0) ? opv[2] : pc + 16'd3;
              OP_JF:   pc <= (opv[1] == 16'd0) ? opv[2] : pc + 16'd3;
              OP_RET:  pc <= stk_top;
              OP_RMEM: st <= ST_MRD;
              OP_OUT:  st <= ST_OUT;
              OP_IN:   st <= ST_IN;
              default: pc <= pc + 16'(step_len);
            endcase
          end
        end
        ST_MRD:  st <= ST_MCAP;
        ST_MCAP: begin pc <= pc + 16'd3; st <= ST_FETCH; end
        ST_OUT:  if (out_ready) begin pc <= pc + 16'd2; st <= ST_FETCH; end
        ST_IN: begin
          if (ev_quit) begin st <= ST_STOP; halted <= 1'b1; end
          else if (in_valid) begin pc <= pc + 16'd2; st <= ST_FETCH; end
        end
        default: st <= ST_STOP;
      endcase
      if (rf_we) regs[opw[1][2:0]] <= rf_wd;
    end
  end

  p_pc_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_seq_retire |=> pc == $past(pc) + 16'($past(step_len)));
  p_stop_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_STOP) |=> (st == ST_STOP) && $stable(pc) && !mem_rd && !mem_wr);
  p_illegal_halt_r1: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> halted);
  p_mem_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));
  p_out_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid && $stable(out_data));
  p_arith_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_we && st == ST_EXEC && (op inside {OP_ADD, OP_MULT, OP_NOT})) |-> !rf_wd[15]);

endmodule

// File: tb/vm16_core_test.sv
module vm16_core_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] mem_addr, mem_wdata;
  logic        mem_rd, mem_wr;
  logic [15:0] mem_rdata = '0;
  logic [7:0]  out_data;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [7:0]  in_data = '0;
  logic        in_valid = 1'b0;
  logic        in_ready, halted, illegal;

  int checks = 0;
  int fails  = 0;
  int wp;
  logic [15:0] mem [0:511];
  logic [7:0]  olog [0:7];
  int ocnt = 0;

  vm16_core uut (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .out_data(out_data),
    .out_valid(out_valid), .out_ready(out_ready), .in_data(in_data),
    .in_valid(in_valid), .in_ready(in_ready), .halted(halted), .illegal(illegal)
  );

  initial forever #2 clk = ~clk;

  always @(posedge clk) begin
    if (mem_wr) mem[mem_addr[8:0]] <= mem_wdata;
    if (mem_rd) mem_rdata <= mem[mem_addr[8:0]];
  end

  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready && ocnt < 8) begin
      olog[ocnt] = out_data;
      ocnt++;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] rg(input int n);
    return 16'h8000 + 16'(n);
  endfunction

  function automatic logic [15:0] ref_op(input int op, input logic [15:0] b, input logic [15:0] c);
    logic [31:0] p;
    case (op)
      4:  return (b == c) ? 16'd1 : 16'd0;
      5:  return (b > c) ? 16'd1 : 16'd0;
      9:  return 16'((32'(b) + 32'(c)) % 32768);
      10: begin p = 32'(b) * 32'(c); return 16'(p % 32768); end
      11: return (c == 0) ? 16'd0 : 16'(b % c);
      12: return b & c;
      13: return b | c;
      14: return 16'h7fff ^ (b & 16'h7fff);
      default: return b;
    endcase
  endfunction

  task automatic clear_mem();
    for (int i = 0; i < 512; i++) mem[i] = '0;
    wp = 0;
    ocnt = 0;
  endtask

  task automatic emit(input logic [15:0] w);
    mem[wp] = w;
    wp++;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wait_halt(input string tag);
    int n;
    n = 0;
    while (!halted && n < 3000) begin @(negedge clk); n++; end
    if (!halted) check({tag, " timeout"}, 0, 1);
  endtask

  task automatic run(input string tag);
    do_reset();
    wait_halt(tag);
  endtask

  int ops [9] = '{1, 4, 5, 9, 10, 11, 12, 13, 14};

  initial begin
    int k;
    logic [15:0] b, c;
    void'($urandom(32'd20240611));

    // R13 reset state and first fetch
    clear_mem();
    mem[100] = 16'hffff;
    emit(16); emit(100); emit(rg(3)); emit(0);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check("R13 reset halted", halted, 0);
    check("R13 reset illegal", illegal, 0);
    check("R13 reset out_valid", out_valid, 0);
    check("R13 first fetch addr", {mem_rd, mem_addr}, {1'b1, 16'd0});
    rst_n = 1'b1;
    wait_halt("R13");
    check("R13 regs cleared", mem[100], 16'd0);
    check("R13 halt normal", {halted, illegal}, 2'b10);
    repeat (10) @(negedge clk);
    check("R13 stopped no access", {halted, mem_rd, mem_wr}, 3'b100);

    // R6 / R2 constrained random arithmetic, register source operand
    for (int i = 0; i < 24; i++) begin
      k = $urandom_range(0, 8);
      b = 16'($urandom) & 16'h7fff;
      c = 16'($urandom) & 16'h7fff;
      if (i % 6 == 0) c = b;
      if (i % 7 == 3) c = c & 16'h000f;
      if (i == 5) begin k = 5; c = 16'd0; end
      if (i == 9) begin k = 3; b = 16'h7fff; c = 16'h7fff; end
      clear_mem();
      emit(1); emit(rg(1)); emit(b);
      emit(16'(ops[k])); emit(rg(2)); emit(rg(1));
      if (ops[k] != 1 && ops[k] != 14) emit(c);
      emit(16); emit(100); emit(rg(2)); emit(0);
      mem[100] = 16'hffff;
      run("R6");
      check($sformatf("R6 op%0d b=%h c=%h", ops[k], b, c), mem[100], ref_op(ops[k], b, c));
      check("R4 lengths legal", illegal, 0);
    end

    // R5 branches
    clear_mem();
    wp = 0;  emit(7); emit(0); emit(20);
    emit(16); emit(101); emit(1);
    emit(8); emit(0); emit(20);
    emit(16); emit(105); emit(16'h0bad); emit(0);
    wp = 20; emit(16); emit(102); emit(2);
    emit(7); emit(5); emit(30);
    emit(16); emit(105); emit(16'h0bad); emit(0);
    wp = 30; emit(16); emit(103); emit(3);
    emit(8); emit(7); emit(40);
    emit(16); emit(104); emit(4); emit(0);
    wp = 40; emit(16); emit(105); emit(16'h0bad); emit(0);
    run("R5");
    check("R5 jt not taken", mem[101], 1);
    check("R5 jf taken", mem[102], 2);
    check("R5 jt taken", mem[103], 3);
    check("R5 jf not taken", mem[104], 4);
    check("R5 no wrong path", mem[105], 0);

    // R7 LIFO with noop, R4 length 1
    clear_mem();
    emit(2); emit(5); emit(21); emit(2); emit(7);
    emit(3); emit(rg(0)); emit(3); emit(rg(1));
    emit(16); emit(100); emit(rg(0)); emit(16); emit(101); emit(rg(1)); emit(0);
    run("R7");
    check("R7 pop order first", mem[100], 7);
    check("R7 pop order second", mem[101], 5);
    check("R7 legal", illegal, 0);

    // R7 overflow
    clear_mem();
    emit(2); emit(1); emit(6); emit(0);
    run("R7 overflow");
    check("R7 push on full illegal", {halted, illegal}, 2'b11);

    // R8 call / ret
    clear_mem();
    emit(17); emit(10); emit(16); emit(103); emit(88); emit(0);
    wp = 10; emit(3); emit(rg(0)); emit(16); emit(104); emit(rg(0));
    emit(2); emit(rg(0)); emit(18);
    run("R8");
    check("R8 return address pushed", mem[104], 2);
    check("R8 ret resumes", mem[103], 88);
    check("R8 legal", illegal, 0);

    // R9 empty pop / ret
    clear_mem();
    emit(3); emit(rg(0)); emit(16); emit(100); emit(9); emit(0);
    run("R9 pop");
    check("R9 empty pop illegal", {halted, illegal}, 2'b11);
    check("R9 no later effect", mem[100], 0);
    clear_mem();
    emit(18); emit(0);
    run("R9 ret");
    check("R9 empty ret illegal", {halted, illegal}, 2'b11);

    // R1 opcode range
    clear_mem();
    emit(22);
    run("R1 bad");
    check("R1 opcode 22 illegal", {halted, illegal}, 2'b11);
    clear_mem();
    emit(21); emit(21); emit(0);
    run("R1 noop");
    check("R1 noop then halt", {halted, illegal}, 2'b10);

    // R2 / R3 operand errors
    clear_mem();
    mem[100] = 16'h1111;
    emit(16); emit(100); emit(16'h8008); emit(0);
    run("R2");
    check("R2 bad source illegal", {halted, illegal}, 2'b11);
    check("R2 no write", mem[100], 16'h1111);
    clear_mem();
    emit(1); emit(5); emit(1); emit(0);
    run("R3");
    check("R3 literal destination illegal", {halted, illegal}, 2'b11);

    // R10 rmem / wmem
    clear_mem();
    mem[300] = 16'h9234;
    emit(15); emit(rg(4)); emit(300); emit(16); emit(100); emit(rg(4)); emit(0);
    run("R10");
    check("R10 rmem then wmem", mem[100], 16'h9234);

    // R11 output handshake
    clear_mem();
    out_ready = 1'b0;
    emit(1); emit(rg(1)); emit(16'h01c3); emit(19); emit(rg(1)); emit(19); emit(16'h5a); emit(0);
    do_reset();
    for (int n = 0; n < 100 && !out_valid; n++) @(negedge clk);
    check("R11 out_data low byte", {out_valid, out_data}, {1'b1, 8'hc3});
    repeat (5) @(negedge clk);
    check("R11 held while not ready", {out_valid, out_data, halted}, {1'b1, 8'hc3, 1'b0});
    out_ready = 1'b1;
    wait_halt("R11");
    check("R11 byte count", ocnt, 2);
    check("R11 second byte", olog[1], 8'h5a);
    check("R11 first byte", olog[0], 8'hc3);

    // R12 input
    clear_mem();
    in_valid = 1'b0;
    in_data = 8'h78;
    emit(20); emit(rg(2)); emit(19); emit(rg(2)); emit(0);
    do_reset();
    repeat (20) @(negedge clk);
    check("R12 waits with in_ready", {in_ready, halted}, 2'b10);
    in_valid = 1'b1;
    wait_halt("R12");
    check("R12 stored code echoed", {ocnt[3:0], olog[0]}, {4'd1, 8'h78});
    clear_mem();
    in_data = 8'h51;
    emit(20); emit(rg(2)); emit(16); emit(100); emit(1); emit(0);
    run("R12 quit");
    check("R12 quit halts normally", {halted, illegal}, 2'b10);
    check("R12 quit stops before next", mem[100], 0);
    in_valid = 1'b0;

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(4 * 150000);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule